// File: doc/BRIEF.md
# Dual clock-synthesizer serial programming sequencer

This block changes the operating point of two serially programmed clock synthesizers, one that sets the core clock and one that sets the memory clock. A host raises a one-cycle start request with a two-bit mode code. The block compares the request with the mode that is currently in force. If the two differ, it shifts a 13-bit word into the core synthesizer, latches it, and then does the same for the memory synthesizer. The whole sequence runs without a break.

Both synthesizers share one serial clock line and one serial data line. Each has its own active-high load strobe. A global load-enable output stays high for as long as a sequence is running. Every step of the sequence is held for a settle interval of `SETTLE` clock cycles. The block flags a request for the mode already in force and sends nothing for it. A query request also produces no serial traffic. The current mode is always visible on an output.

Top module: `clksynth_seq`

## Requirements
- R1: After reset the serial clock, serial data, load-enable, both strobes, busy, done and already are all low, and the current mode is power-save (`cur_mode_o` = 1).
- R2: Mode code encoding: `mode_i[1]` = 0 means a change request, with `mode_i[0]` = 0 for high-speed and 1 for power-save. A change request that differs from the current mode starts a sequence, and busy is high from the next cycle until the sequence ends.
- R3: Each frame is 13 bits long and is sent as three fields: a 2-bit T field, then a 2-bit N field, then a 9-bit M field, all MSB first. T and N are zero. M is 0x014 (core) and 0x018 (memory) in high-speed mode, and 0x00E (core) and 0x010 (memory) in power-save mode.
- R4: Each bit takes three steps of `SETTLE` cycles each. In the first step the data line takes the new value and the serial clock keeps its previous level. In the second step the clock goes low. In the third step the clock goes high. Data is stable across the rising edge.
- R5: Before each frame, load-enable is high while the serial clock, the serial data and that synthesizer's strobe are low, for `SETTLE` cycles.
- R6: After a frame's last bit, that synthesizer's strobe is high for `SETTLE` cycles and then low for `SETTLE` cycles, with the serial clock held high. The two strobes are never high together, and neither is high without load-enable.
- R7: The core frame and its strobe pulse finish before the memory frame begins. A sequence lasts exactly 84*`SETTLE` cycles.
- R8: On completion, done is high for one cycle. In that same cycle the current mode takes the requested value and busy and load-enable fall. The current mode changes at no other time.
- R9: A change request equal to the current mode raises already for one cycle on the next cycle. It produces no serial activity and no done.
- R10: A query (`mode_i[1]` = 1) produces no serial activity, no busy, no done and no already, and leaves the current mode unchanged.
- R11: Start requests that arrive while busy have no effect on the running sequence or on the current mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request strobe |
| mode_i | input | 2 | Bit 1: query; bit 0: 0 high-speed, 1 power-save |
| sclk_o | output | 1 | Shared serial clock |
| sdata_o | output | 1 | Shared serial data |
| load_en_o | output | 1 | Global load-enable, high during a sequence |
| core_ld_o | output | 1 | Core synthesizer load strobe |
| mem_ld_o | output | 1 | Memory synthesizer load strobe |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| already_o | output | 1 | One-cycle pulse: requested mode already active |
| cur_mode_o | output | 1 | Mode now in force (0 high-speed, 1 power-save) |

## Verification
The update of the current mode and the comparison made for a fresh request can land on the same edge. This happens when a new request is sampled in the very cycle that done is shown. The bench issues a request for the mode that has just been programmed exactly in that done cycle. The expected result is an already pulse with no new traffic, because the request must be judged against the updated mode. The bench also issues a request for the opposite mode right after a completion and expects a full back-to-back sequence. A per-cycle behavioural model judges every output, and a rising-edge bit capture rebuilds both 13-bit frames for comparison.

// File: rtl/clksynth_pkg.sv
package clksynth_pkg;
    localparam int T_W     = 2;
    localparam int N_W     = 2;
    localparam int M_W     = 9;
    localparam int FRAME_W = T_W + N_W + M_W;
    localparam int IDX_W   = $clog2(FRAME_W);

    localparam logic [T_W-1:0] T_FIELD = '0;
    localparam logic [N_W-1:0] N_FIELD = '0;

    localparam logic [M_W-1:0] M_CORE_FAST = 9'h014;
    localparam logic [M_W-1:0] M_MEM_FAST  = 9'h018;
    localparam logic [M_W-1:0] M_CORE_SAVE = 9'h00E;
    localparam logic [M_W-1:0] M_MEM_SAVE  = 9'h010;

    localparam logic MODE_FAST = 1'b0;
    localparam logic MODE_SAVE = 1'b1;
    localparam logic TGT_CORE  = 1'b0;
    localparam logic TGT_MEM   = 1'b1;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PREP,
        PH_DATA,
        PH_LOW,
        PH_HIGH,
        PH_STRB_HI,
        PH_STRB_LO
    } phase_e;
endpackage

// File: rtl/clksynth_settle.sv
module clksynth_settle #(
    parameter int SETTLE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic expire_o
);
    localparam int CNT_W = (SETTLE > 1) ? $clog2(SETTLE + 1) : 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart_i)
            cnt_d = CNT_W'(SETTLE - 1);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire_o = (cnt_q == '0);
endmodule

// File: rtl/clksynth_frame_sel.sv
module clksynth_frame_sel
    import clksynth_pkg::*;
(
    input  logic               mode_i,
    input  logic               tgt_i,
    output logic [FRAME_W-1:0] frame_o
);
    logic [M_W-1:0] m_val;

    always_comb begin
        unique case ({mode_i, tgt_i})
            {MODE_FAST, TGT_CORE}: m_val = M_CORE_FAST;
            {MODE_FAST, TGT_MEM}:  m_val = M_MEM_FAST;
            {MODE_SAVE, TGT_CORE}: m_val = M_CORE_SAVE;
            default:               m_val = M_MEM_SAVE;
        endcase
    end

    assign frame_o = {T_FIELD, N_FIELD, m_val};
endmodule

// File: rtl/clksynth_seq.sv
module clksynth_seq
    import clksynth_pkg::*;
#(
    parameter int SETTLE = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [1:0] mode_i,
    output logic       sclk_o,
    output logic       sdata_o,
    output logic       load_en_o,
    output logic       core_ld_o,
    output logic       mem_ld_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       already_o,
    output logic       cur_mode_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

    typedef struct packed {
        phase_e           phase;
        logic             tgt;
        logic [IDX_W-1:0] idx;
        logic             mode_new;
        logic             cur_mode;
        logic             busy;
        logic             done;
        logic             already;
        logic             load_en;
        logic             sclk;
        logic             sdata;
        logic             core_ld;
        logic             mem_ld;
    } seq_state_t;

    seq_state_t       d, q;
    logic             restart;
    logic             expire;
    logic [FRAME_W-1:0] frame;
    logic [IDX_W-1:0] bit_pos;

    clksynth_settle #(.SETTLE(SETTLE)) settle_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .expire_o  (expire)
    );

    // Bits of the next state are only needed when the target and mode are unchanged.
    clksynth_frame_sel frame_sel_i (
        .mode_i  (q.mode_new),
        .tgt_i   (q.tgt),
        .frame_o (frame)
    );

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.already = 1'b0;
        restart   = 1'b0;

        if (q.phase == PH_IDLE) begin
            if (start_i && !mode_i[1]) begin
                if (mode_i[0] == q.cur_mode) begin
                    d.already = 1'b1;
                end else begin
                    d.phase    = PH_PREP;
                    d.tgt      = TGT_CORE;
                    d.idx      = '0;
                    d.mode_new = mode_i[0];
                    restart    = 1'b1;
                end
            end
        end else if (expire) begin
            restart = 1'b1;
            unique case (q.phase)
                PH_PREP: begin
                    d.phase = PH_DATA;
                    d.idx   = '0;
                end
                PH_DATA: d.phase = PH_LOW;
                PH_LOW:  d.phase = PH_HIGH;
                PH_HIGH: begin
                    if (q.idx == LAST_IDX) begin
                        d.phase = PH_STRB_HI;
                    end else begin
                        d.phase = PH_DATA;
                        d.idx   = q.idx + 1'b1;
                    end
                end
                PH_STRB_HI: d.phase = PH_STRB_LO;
                PH_STRB_LO: begin
                    if (q.tgt == TGT_CORE) begin
                        d.tgt   = TGT_MEM;
                        d.phase = PH_PREP;
                    end else begin
                        d.phase    = PH_IDLE;
                        d.done     = 1'b1;
                        d.cur_mode = q.mode_new;
                    end
                end
                default: d.phase = PH_IDLE;
            endcase
        end

        // Registered pin values derived from the next phase.
        bit_pos   = LAST_IDX - d.idx;
        d.busy    = (d.phase != PH_IDLE);
        d.load_en = d.busy;
        unique case (d.phase)
            PH_DATA: begin
                d.sclk  = (d.idx != '0);
                d.sdata = frame[bit_pos];
            end
            PH_LOW: begin
                d.sclk  = 1'b0;
                d.sdata = frame[bit_pos];
            end
            PH_HIGH: begin
                d.sclk  = 1'b1;
                d.sdata = frame[bit_pos];
            end
            PH_STRB_HI, PH_STRB_LO: begin
                d.sclk  = 1'b1;
                d.sdata = 1'b0;
            end
            default: begin
                d.sclk  = 1'b0;
                d.sdata = 1'b0;
            end
        endcase
        d.core_ld = (d.phase == PH_STRB_HI) && (d.tgt == TGT_CORE);
        d.mem_ld  = (d.phase == PH_STRB_HI) && (d.tgt == TGT_MEM);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.phase    <= PH_IDLE;
            q.cur_mode <= MODE_SAVE;
        end else begin
            q <= d;
        end
    end

    assign sclk_o     = q.sclk;
    assign sdata_o    = q.sdata;
    assign load_en_o  = q.load_en;
    assign core_ld_o  = q.core_ld;
    assign mem_ld_o   = q.mem_ld;
    assign busy_o     = q.busy;
    assign done_o     = q.done;
    assign already_o  = q.already;
    assign cur_mode_o = q.cur_mode;

    // Data must already be stable when the serial clock rises.
    assert_data_before_clock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> $stable(sdata_o));

    assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({core_ld_o, mem_ld_o}));

    assert_strobe_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (core_ld_o || mem_ld_o) |-> (load_en_o && sclk_o));

    assert_done_follows_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(busy_o) && !busy_o && !load_en_o));

    assert_mode_moves_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_mode_o) |-> done_o);

    assert_already_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        already_o |-> (!busy_o && !done_o && !sclk_o));
endmodule

// File: tb/clksynth_seq_tb_top.sv
`timescale 1ns/1ps
module clksynth_seq_tb_top;
    localparam int SETTLE = 5;
    localparam int SEQ_CYC = 84 * SETTLE;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] mode = 2'b00;
    logic sclk, sdata, load_en, core_ld, mem_ld, busy, done, already, cur_mode;

    always #2 clk = ~clk;

    clksynth_seq #(.SETTLE(SETTLE)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode),
        .sclk_o(sclk), .sdata_o(sdata), .load_en_o(load_en),
        .core_ld_o(core_ld), .mem_ld_o(mem_ld), .busy_o(busy),
        .done_o(done), .already_o(already), .cur_mode_o(cur_mode)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // Model word: {busy, load_en, sclk, sdata, core_ld, mem_ld}
    logic [5:0] exp_q[$];
    logic [5:0] exp_w = '0;
    logic exp_done = 0, exp_already = 0, exp_cur = 1;
    logic pend = 0, pend_mode = 0;

    logic prev_sclk = 0, prev_cld = 0, prev_mld = 0;
    logic [12:0] shreg = '0;
    int nbits = 0;
    bit saw_core = 0;
    int frames = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [12:0] exp_frame(input logic md, input logic tgt);
        if (!md) return tgt ? 13'h018 : 13'h014;
        return tgt ? 13'h010 : 13'h00E;
    endfunction

    task automatic push_n(input logic [5:0] w);
        for (int k = 0; k < SETTLE; k++) exp_q.push_back(w);
    endtask

    task automatic build(input logic md);
        for (int t = 0; t < 2; t++) begin
            logic [12:0] f = exp_frame(md, t[0]);
            logic pc = 1'b0;
            push_n(6'b110000);
            for (int i = 12; i >= 0; i--) begin
                push_n({2'b11, pc, f[i], 2'b00});
                push_n({2'b11, 1'b0, f[i], 2'b00});
                push_n({2'b11, 1'b1, f[i], 2'b00});
                pc = 1'b1;
            end
            push_n({4'b1110, (t == 0), (t == 1)});
            push_n(6'b111000);
        end
    endtask

    task automatic model_edge(input logic st, input logic [1:0] md);
        exp_done = 0;
        exp_already = 0;
        if (exp_q.size() > 0) begin
            exp_w = exp_q.pop_front();
            if (exp_q.size() == 0) pend = 1;
        end else if (pend) begin
            exp_w = '0;
            exp_done = 1;
            exp_cur = pend_mode;
            pend = 0;
        end else begin
            exp_w = '0;
            if (st && !md[1]) begin
                if (md[0] == exp_cur) exp_already = 1;
                else begin
                    build(md[0]);
                    pend_mode = md[0];
                    exp_w = exp_q.pop_front();
                end
            end
        end
    endtask

    task automatic compare();
        chk("R2", "busy", busy, exp_w[5]);
        chk("R5", "load_en", load_en, exp_w[4]);
        chk("R4", "sclk", sclk, exp_w[3]);
        chk("R4", "sdata", sdata, exp_w[2]);
        chk("R6", "core_ld", core_ld, exp_w[1]);
        chk("R6", "mem_ld", mem_ld, exp_w[0]);
        chk("R8", "done", done, exp_done);
        chk("R9", "already", already, exp_already);
        chk("R8", "cur_mode", cur_mode, exp_cur);
        if (sclk && !prev_sclk) begin
            shreg = {shreg[11:0], sdata};
            nbits++;
        end
        if (core_ld && !prev_cld) begin
            chk("R3", "core frame", shreg, exp_frame(pend_mode, 1'b0));
            chk("R3", "core bit count", nbits, 13);
            chk("R7", "core before memory", saw_core, 0);
            saw_core = 1;
            nbits = 0;
            frames++;
        end
        if (mem_ld && !prev_mld) begin
            chk("R3", "memory frame", shreg, exp_frame(pend_mode, 1'b1));
            chk("R3", "memory bit count", nbits, 13);
            chk("R7", "core frame already sent", saw_core, 1);
            saw_core = 0;
            nbits = 0;
            frames++;
        end
        prev_sclk = sclk;
        prev_cld = core_ld;
        prev_mld = mem_ld;
    endtask

    task automatic cyc(input logic st, input logic [1:0] md);
        start = st;
        mode = md;
        @(posedge clk);
        model_edge(st, md);
        @(negedge clk);
        start = 0;
        compare();
    endtask

    task automatic run_out();
        while (exp_q.size() > 0 || pend) cyc(1'b0, 2'b00);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int len;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1", "idle pins", {sclk, sdata, load_en, core_ld, mem_ld}, 0);
        chk("R1", "flags", {busy, done, already}, 0);
        chk("R1", "cur_mode", cur_mode, 1);
        compare();
        // R10 queries
        cyc(1, 2'b10);
        cyc(0, 2'b00);
        cyc(1, 2'b11);
        cyc(0, 2'b00);
        chk("R10", "mode after query", cur_mode, 1);
        // R9 same mode
        cyc(1, 2'b01);
        cyc(0, 2'b00);
        // R2 change to high-speed, R11 requests during busy
        cyc(1, 2'b00);
        len = 1;
        for (int i = 0; i < 200; i++) begin
            cyc((i % 37) == 3, (i % 2) ? 2'b01 : 2'b10);
            len++;
        end
        while (exp_q.size() > 0) begin
            cyc(1'b0, 2'b00);
            len++;
        end
        chk("R7", "sequence length", len, SEQ_CYC);
        cyc(0, 2'b00);
        chk("R8", "fast mode reached", cur_mode, 0);
        // request the just-programmed mode in the done cycle
        cyc(1, 2'b00);
        cyc(0, 2'b00);
        // back to power-save, then immediately high-speed again
        cyc(1, 2'b01);
        run_out();
        chk("R8", "save mode reached", cur_mode, 1);
        cyc(1, 2'b00);
        run_out();
        chk("R11", "mode after busy requests", cur_mode, 0);
        cyc(1, 2'b11);
        cyc(0, 2'b00);
        chk("R7", "frames seen", frames, 6);
        summary();
    end
endmodule